// File: doc/BRIEF.md
# Multi-Format Serial Audio Output Formatter

This block turns a stereo pair of 16-bit processed audio samples into one serial data line. The bit clock and the word clock come from outside the block. Both are sampled in the block's own system clock domain, and the serial line is relaunched after each falling edge of the bit clock, so that a receiver can sample it on the rising edge. A high word clock carries the left channel and a low word clock carries the right channel. A rising word clock edge opens a frame.

A 2-bit format code chooses the frame layout. Three layouts use 24-bit channel slots (48 bit clocks per frame) with the word LSB-justified: a plain 16-bit word, an 18-bit word whose two lowest bits are zero, or a 20-bit word whose four lowest bits are zero. The fourth layout uses 32-bit slots (64 bit clocks per frame) with the 16-bit word MSB-justified one bit clock after the word clock edge. Every layout sends MSB first and drives unused slot positions low.

Samples arrive on a valid/ready stream with a single holding entry. Ready is high while that entry is empty, and a sample is taken on any clock cycle in which valid and ready are both high. A sender that sees ready low must hold its sample and valid until ready returns. At each frame start the held pair moves into a shadow pair that feeds the frame, and the entry empties. The serial side cannot be stalled. If no sample is held when a frame starts, that frame carries silence.

Top module: `serial_audio_fmt`

## Requirements
- R1: After reset, sdo_o is low and smp_ready_o is high.
- R2: Format 00: each 24-bit slot carries the 16-bit sample MSB first in slot positions 8 to 23, and positions 0 to 7 are low. Position 0 is the bit launched at the first bit clock falling edge after a word clock edge.
- R3: Format 01: each 24-bit slot carries the 18-bit word {sample, 2'b00} MSB first in positions 6 to 23, and positions 0 to 5 are low.
- R4: Format 10: each 24-bit slot carries the 20-bit word {sample, 4'b0000} MSB first in positions 4 to 23, and positions 0 to 3 are low.
- R5: Format 11: each 32-bit slot has position 0 low, the sample MSB first in positions 1 to 16, and positions 17 to 31 low.
- R6: A high word clock selects the left sample and a low word clock selects the right sample. Slot position counting restarts at every word clock edge. sdo_o changes only in response to a bit clock falling edge.
- R7: While a sample is held, smp_ready_o is low, and further valid samples are not taken until the next frame start empties the entry.
- R8: A sample accepted while a frame is in progress does not alter that frame and is sent in the next frame.
- R9: A change of fmt_sel_i takes effect only at the next word clock rising edge.
- R10: If no sample is held at a frame start, both slots of that frame are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | External bit clock |
| wclk_i | input | 1 | External word clock, high for left |
| fmt_sel_i | input | 2 | Frame layout code |
| smp_valid_i | input | 1 | Sample pair valid |
| smp_ready_o | output | 1 | Holding entry empty |
| smp_left_i | input | 16 | Left sample |
| smp_right_i | input | 16 | Right sample |
| sdo_o | output | 1 | Serial data out |

## Verification
The assertions assume that the bit clock holds each level for at least three system clock cycles. They also assume that the word clock changes only together with a bit clock falling edge, so both lines pass through the synchronizer in the same cycle. The stimulus keeps each bit clock level for four system clock cycles. It changes the word clock only in the same step as a falling bit clock edge, drives all inputs on the falling system clock edge, and keeps valid high until ready is seen.

// File: rtl/saf_pkg.sv
package saf_pkg;
  typedef enum logic [1:0] {
    FMT_L16  = 2'b00,
    FMT_L18  = 2'b01,
    FMT_L20  = 2'b10,
    FMT_WIDE = 2'b11
  } fmt_e;

  localparam int SAF_DATA_W      = 16;
  localparam int SAF_POS_W       = 6;
  localparam int SAF_NARROW_SLOT = 24;
  localparam int SAF_WIDE_DELAY  = 1;
  localparam int SAF_PAD_MID     = 2;
  localparam int SAF_PAD_HIGH    = 4;
endpackage

// File: rtl/saf_sync.sv
module saf_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] async_i,
  output logic [LINES-1:0] sync_o,
  output logic [LINES-1:0] prev_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], async_i[g]};
    end
    assign sync_o[g] = chain[STAGES-1];
    assign prev_o[g] = chain[STAGES];
  end
endmodule

// File: rtl/saf_slot_track.sv
module saf_slot_track #(
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_s,
  input  logic             bclk_prev,
  input  logic             wclk_s,
  output logic             tick_o,
  output logic             slot_start_o,
  output logic             frame_start_o,
  output logic [POS_W-1:0] pos_nxt_o
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] pos_q;
  logic             wclk_last;

  assign tick_o        = bclk_prev & ~bclk_s;
  assign slot_start_o  = tick_o & (wclk_s != wclk_last);
  assign frame_start_o = slot_start_o & wclk_s;

  always_comb begin
    if (slot_start_o)        pos_nxt_o = '0;
    else if (pos_q == POS_MAX) pos_nxt_o = POS_MAX;
    else                     pos_nxt_o = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= POS_MAX;
      wclk_last <= 1'b0;
    end else if (tick_o) begin
      pos_q     <= pos_nxt_o;
      wclk_last <= wclk_s;
    end
  end
endmodule

// File: rtl/saf_sample_stage.sv
module saf_sample_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  input  logic              frame_start_i,
  output logic [DATA_W-1:0] sh_left_o,
  output logic [DATA_W-1:0] sh_right_o
);
  logic              full_q;
  logic [DATA_W-1:0] hold_l, hold_r;
  logic              take;

  assign ready_o = ~full_q;
  assign take    = valid_i & ~full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q     <= 1'b0;
      hold_l     <= '0;
      hold_r     <= '0;
      sh_left_o  <= '0;
      sh_right_o <= '0;
    end else begin
      if (take) begin
        hold_l <= left_i;
        hold_r <= right_i;
      end
      if (frame_start_i) begin
        sh_left_o  <= full_q ? hold_l : '0;
        sh_right_o <= full_q ? hold_r : '0;
        full_q     <= take;
      end else if (take) begin
        full_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/saf_bit_select.sv
module saf_bit_select
  import saf_pkg::*;
#(
  parameter int DATA_W      = SAF_DATA_W,
  parameter int POS_W       = SAF_POS_W,
  parameter int NARROW_SLOT = SAF_NARROW_SLOT,
  parameter int WIDE_DELAY  = SAF_WIDE_DELAY,
  parameter int PAD_MID     = SAF_PAD_MID,
  parameter int PAD_HIGH    = SAF_PAD_HIGH
) (
  input  fmt_e              fmt_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [POS_W-1:0]  pos_i,
  output logic              bit_o
);
  localparam int IDX_W = $clog2(DATA_W);

  int pos_n, pad, first, off;

  always_comb begin
    pos_n = int'(pos_i);
    bit_o = 1'b0;
    pad   = 0;
    first = 0;
    off   = 0;
    case (fmt_i)
      FMT_WIDE: begin
        off = pos_n - WIDE_DELAY;
      end
      default: begin
        if (fmt_i == FMT_L18)      pad = PAD_MID;
        else if (fmt_i == FMT_L20) pad = PAD_HIGH;
        first = NARROW_SLOT - DATA_W - pad;
        off   = pos_n - first;
      end
    endcase
    if (off >= 0 && off < DATA_W)
      bit_o = word_i[IDX_W'(DATA_W - 1 - off)];
  end
endmodule

// File: rtl/serial_audio_fmt.sv
module serial_audio_fmt
  import saf_pkg::*;
#(
  parameter int DATA_W      = SAF_DATA_W,
  parameter int POS_W       = SAF_POS_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              wclk_i,
  input  logic [1:0]        fmt_sel_i,
  input  logic              smp_valid_i,
  output logic              smp_ready_o,
  input  logic [DATA_W-1:0] smp_left_i,
  input  logic [DATA_W-1:0] smp_right_i,
  output logic              sdo_o
);
  logic [1:0]        line_s, line_p;
  logic              tick, slot_start, frame_start;
  logic [POS_W-1:0]  pos_nxt;
  logic [DATA_W-1:0] sh_l, sh_r, cur_word;
  fmt_e              fmt_act;
  logic              nxt_bit;

  saf_sync #(.LINES(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .async_i({wclk_i, bclk_i}),
    .sync_o(line_s), .prev_o(line_p)
  );

  saf_slot_track #(.POS_W(POS_W)) track_i (
    .clk(clk), .rst_n(rst_n),
    .bclk_s(line_s[0]), .bclk_prev(line_p[0]), .wclk_s(line_s[1]),
    .tick_o(tick), .slot_start_o(slot_start), .frame_start_o(frame_start),
    .pos_nxt_o(pos_nxt)
  );

  saf_sample_stage #(.DATA_W(DATA_W)) stage_i (
    .clk(clk), .rst_n(rst_n),
    .valid_i(smp_valid_i), .ready_o(smp_ready_o),
    .left_i(smp_left_i), .right_i(smp_right_i),
    .frame_start_i(frame_start),
    .sh_left_o(sh_l), .sh_right_o(sh_r)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           fmt_act <= FMT_L16;
    else if (frame_start) fmt_act <= fmt_e'(fmt_sel_i);
  end

  assign cur_word = line_s[1] ? sh_l : sh_r;

  saf_bit_select #(.DATA_W(DATA_W), .POS_W(POS_W)) sel_i (
    .fmt_i(fmt_act), .word_i(cur_word), .pos_i(pos_nxt), .bit_o(nxt_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sdo_o <= 1'b0;
    else if (tick) sdo_o <= slot_start ? 1'b0 : nxt_bit;
  end
endmodule

// File: rtl/saf_checker.sv
module saf_checker #(
  parameter int DATA_W      = 16,
  parameter int POS_W       = 6,
  parameter int NARROW_SLOT = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             frame_start,
  input logic [POS_W-1:0] pos_nxt,
  input logic [1:0]       fmt_act,
  input logic             sdo,
  input logic             smp_valid,
  input logic             smp_ready
);
  localparam logic [POS_W-1:0] LEAD16 = POS_W'(NARROW_SLOT - DATA_W);
  localparam logic [POS_W-1:0] PAD18  = POS_W'(NARROW_SLOT - 2);
  localparam logic [POS_W-1:0] PAD20  = POS_W'(NARROW_SLOT - 4);
  localparam logic [POS_W-1:0] WEND   = POS_W'(DATA_W);

  assert_slot_head_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick && pos_nxt == '0 |=> !sdo);
  assert_sdo_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sdo));
  assert_lead_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && fmt_act == 2'b00 && pos_nxt < LEAD16 |=> !sdo);
  assert_pad_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && fmt_act == 2'b01 && pos_nxt >= PAD18 |=> !sdo);
  assert_pad_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick && fmt_act == 2'b10 && pos_nxt >= PAD20 |=> !sdo);
  assert_tail_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick && fmt_act == 2'b11 && pos_nxt > WEND |=> !sdo);
  assert_fmt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(fmt_act));
  assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && smp_ready && !frame_start |=> !smp_ready);
endmodule

bind serial_audio_fmt saf_checker #(.DATA_W(DATA_W), .POS_W(POS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .frame_start(frame_start),
  .pos_nxt(pos_nxt), .fmt_act(fmt_act), .sdo(sdo_o),
  .smp_valid(smp_valid_i), .smp_ready(smp_ready_o)
);

// File: tb/serial_audio_fmt_tb_top.sv
module serial_audio_fmt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b1;
  logic        wclk = 1'b0;
  logic [1:0]  fmt_sel = 2'b00;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_l = '0, smp_r = '0;
  logic        sdo;

  int          tests = 0;
  int          fails = 0;
  logic        done = 1'b0;
  logic [31:0] got_l, got_r;

  always #5 clk = ~clk;

  serial_audio_fmt dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .wclk_i(wclk),
    .fmt_sel_i(fmt_sel), .smp_valid_i(smp_valid), .smp_ready_o(smp_ready),
    .smp_left_i(smp_l), .smp_right_i(smp_r), .sdo_o(sdo)
  );

  function automatic logic [31:0] exp_slot(input logic [1:0] f, input logic [15:0] s);
    case (f)
      2'b00:   return {8'h00, s, 8'h00};
      2'b01:   return {6'b0, s, 2'b0, 8'h00};
      2'b10:   return {4'b0, s, 4'b0, 8'h00};
      default: return {1'b0, s, 15'b0};
    endcase
  endfunction

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk);
    smp_valid = 1'b1; smp_l = l; smp_r = r;
    while (!smp_ready) @(negedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic bit_cycle(input logic wv, output logic b);
    @(negedge clk);
    bclk = 1'b0; wclk = wv;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    b = sdo;
    repeat (3) @(negedge clk);
  endtask

  // mid_kind: 0 none, 1 push (ml, mr) at left bit 5, 2 set fmt_sel to mf at left bit 5
  task automatic run_frame(input int len, input int mid_kind,
                           input logic [15:0] ml, input logic [15:0] mr,
                           input logic [1:0] mf);
    logic b;
    got_l = '0; got_r = '0;
    for (int ch = 0; ch < 2; ch++) begin
      for (int i = 0; i < len; i++) begin
        bit_cycle(ch == 0, b);
        if (ch == 0) got_l[31-i] = b; else got_r[31-i] = b;
        if (ch == 0 && i == 5) begin
          if (mid_kind == 1) push(ml, mr);
          else if (mid_kind == 2) fmt_sel = mf;
        end
      end
    end
  endtask

  function automatic int slot_len(input logic [1:0] f);
    return (f == 2'b11) ? 32 : 24;
  endfunction

  task automatic t_reset();
    check_eq("R1", "sdo after reset", {31'b0, sdo}, 32'h0);
    check_eq("R1", "ready after reset", {31'b0, smp_ready}, 32'h1);
  endtask

  task automatic t_format(input string req, input logic [1:0] f,
                          input logic [15:0] l, input logic [15:0] r);
    @(negedge clk);
    fmt_sel = f;
    push(l, r);
    run_frame(slot_len(f), 0, '0, '0, f);
    check_eq(req, "left slot", got_l, exp_slot(f, l));
    check_eq(req, "right slot R6", got_r, exp_slot(f, r));
  endtask

  task automatic t_backpressure();
    fmt_sel = 2'b00;
    push(16'h1357, 16'h2468);
    @(negedge clk);
    check_eq("R7", "ready while held", {31'b0, smp_ready}, 32'h0);
    smp_valid = 1'b1; smp_l = 16'hDEAD; smp_r = 16'hBEEF;
    repeat (5) @(negedge clk);
    check_eq("R7", "ready stays low", {31'b0, smp_ready}, 32'h0);
    smp_valid = 1'b0;
    run_frame(24, 0, '0, '0, 2'b00);
    check_eq("R7", "held left sent", got_l, exp_slot(2'b00, 16'h1357));
    check_eq("R7", "held right sent", got_r, exp_slot(2'b00, 16'h2468));
    check_eq("R7", "ready after frame start", {31'b0, smp_ready}, 32'h1);
  endtask

  task automatic t_mid_sample();
    fmt_sel = 2'b01;
    push(16'hA5C3, 16'h0F0F);
    run_frame(24, 1, 16'h7E81, 16'hC001, 2'b01);
    check_eq("R8", "current left kept", got_l, exp_slot(2'b01, 16'hA5C3));
    check_eq("R8", "current right kept", got_r, exp_slot(2'b01, 16'h0F0F));
    run_frame(24, 0, '0, '0, 2'b01);
    check_eq("R8", "next left new", got_l, exp_slot(2'b01, 16'h7E81));
    check_eq("R8", "next right new", got_r, exp_slot(2'b01, 16'hC001));
  endtask

  task automatic t_mid_format();
    fmt_sel = 2'b00;
    push(16'h9ABC, 16'h4321);
    run_frame(24, 2, '0, '0, 2'b11);
    check_eq("R9", "old format left", got_l, exp_slot(2'b00, 16'h9ABC));
    check_eq("R9", "old format right", got_r, exp_slot(2'b00, 16'h4321));
    push(16'hF00D, 16'h0BAD);
    run_frame(32, 0, '0, '0, 2'b11);
    check_eq("R9", "new format left", got_l, exp_slot(2'b11, 16'hF00D));
    check_eq("R9", "new format right", got_r, exp_slot(2'b11, 16'h0BAD));
  endtask

  task automatic t_underrun();
    fmt_sel = 2'b10;
    run_frame(24, 0, '0, '0, 2'b10);
    check_eq("R10", "silent left", got_l, 32'h0);
    check_eq("R10", "silent right", got_r, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_format("R2", 2'b00, 16'h8001, 16'h7FFE);
    t_format("R2", 2'b00, 16'hFFFF, 16'h1234);
    t_format("R3", 2'b01, 16'hFFFF, 16'h8421);
    t_format("R4", 2'b10, 16'hFFFF, 16'hC3A5);
    t_format("R5", 2'b11, 16'h8001, 16'hFFFF);
    t_format("R5", 2'b11, 16'h5A5A, 16'h0001);
    t_backpressure();
    t_mid_sample();
    t_mid_format();
    t_underrun();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2ms;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule